// File: doc/BRIEF.md
# Strap-Addressed Clock Controller Register Bank

This block is the byte-wide register file behind the serial slave port of a clock-generator controller. The serial protocol engine sits elsewhere and reaches the bank through a flat strobe interface: a write enable with address and data, and a read enable that returns data in the same cycle. Two three-level strap inputs set the 7-bit slave address that the protocol engine should answer to. One strap combination instead puts the port in SPI mode, and in that mode the top bit of the register address is not decoded.

The bank holds nine byte registers: divider settings, two control bytes, one status byte and one reserved byte. Reserved bits ignore writes and read back zero. The status byte follows the live monitor inputs and cannot be written. One control bit acts as a software master reset: writing it emits a one-cycle reset pulse and then returns every register to its power-up value. The decoded divider and control fields are brought out as ports for the rest of the controller.

Top module: `clkcfg_regs`

## Requirements
- R1: Each strap input is a 2-bit level code: 00 is low, 01 is open, 10 or 11 is high. With levels counted low=0, open=1, high=2, the slave address is 7'h68 + 3*level(strapA) + level(strapB). strapA is the more significant digit.
- R2: When both straps are high, spiMode is 1 and slaveAddr is 0. For every other combination spiMode is 0.
- R3: The straps are captured on the first clock edge after rstN is released. Later strap changes, including changes around a software reset, do not alter slaveAddr or spiMode.
- R4: After rstN, register 5 reads 8'h60 and every other register reads 8'h00.
- R5: When spiMode is 0, the full 8-bit address selects registers 0 to 8. Any address of 9 or above, including addresses with bit 7 set, hits nothing: a write there changes no register, and a read there returns 0.
- R6: When spiMode is 1, address bit 7 is ignored, so only bits 6:0 select the register.
- R7: Reserved bits ignore writes and read zero. These are register 2 bit 0, register 3 bits 4:0, register 4 bits 4:0, register 6 bit 0 and all of register 8.
- R8: Register 6 bit 3 always reads 0, whatever is written to it.
- R9: Register 7 reads {1'b0, statusIn[4:0], 2'b00}, one cycle after statusIn is presented. statusIn carries input-0 fail, input-1 fail, active input, PLL unlocked and holdover, from bit 4 down to bit 0. Writes to register 7 are ignored.
- R10: Writing 1 to register 6 bit 4 raises mrPulse for exactly the next cycle. At the following edge every register returns to its R4 value, so the bit clears.
- R11: divP is register 0. divM is {register 1, register 2 bits 7:1}. divN0 is register 3 bits 7:5 and divN1 is register 4 bits 7:5. ctrlA and ctrlB are registers 5 and 6.
- R12: rdData is combinational from addr while rdEn is high, and it is 0 while rdEn is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low power-up / external master reset |
| strapA | input | 2 | First strap level code (more significant digit) |
| strapB | input | 2 | Second strap level code |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data |
| statusIn | input | 5 | Live monitor flags for the status register |
| slaveAddr | output | 7 | Decoded slave address (0 in SPI mode) |
| spiMode | output | 1 | Port operates as SPI |
| mrPulse | output | 1 | One-cycle software master reset pulse |
| divP | output | 8 | P divider field |
| divM | output | 15 | M divider field |
| divN0 | output | 3 | N0 divider code |
| divN1 | output | 3 | N1 divider code |
| ctrlA | output | 8 | Control register 5 |
| ctrlB | output | 8 | Control register 6 |

## Verification
Most internal faults show up at the ports with no delay. A wrong mask or a wrong reset value is visible on rdData in the first read after the write or reset. It is also visible at once on the divider field ports.

A wrong strap capture shows on slaveAddr two edges after reset release and stays wrong for the rest of the run. A capture that wrongly repeats shows only once the straps are moved.

A fault in the software reset path shows on mrPulse one cycle after the triggering write. The registers it should have restored still hold stale values at the next read.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
  localparam int NumRegs   = 9;
  localparam int DataW     = 8;
  localparam int StatW     = 5;
  localparam int StatusIdx = 7;
  localparam int CtrlBIdx  = 6;
  localparam int SwRstBit  = 4;

  typedef struct packed {
    logic [NumRegs-1:0] wrSel;
    logic [NumRegs-1:0] rdSel;
  } strobe_t;

  // writable bits per register; others are reserved or forced zero
  function automatic logic [DataW-1:0] wrMask(int idx);
    case (idx)
      2:       return 8'hFE;
      3, 4:    return 8'hE0;
      6:       return 8'hF6;
      7, 8:    return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  function automatic logic [DataW-1:0] rstVal(int idx);
    return (idx == 5) ? 8'h60 : 8'h00;
  endfunction
endpackage

// File: rtl/clkcfg_ctrl.sv
module clkcfg_ctrl
  import clkcfg_pkg::*;
#(
  parameter int Regs  = NumRegs,
  parameter int AddrW = 8,
  parameter int SlvW  = 7,
  parameter logic [SlvW-1:0] BaseAddr = 7'h68
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       strapA,
  input  logic [1:0]       strapB,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic [AddrW-1:0] addr,
  output strobe_t          strobe,
  output logic [SlvW-1:0]  slaveAddr,
  output logic             spiMode
);
  localparam int CodeW   = 4;
  localparam int SpiCode = 8;

  function automatic logic [CodeW-1:0] level(logic [1:0] s);
    return s[1] ? CodeW'(2) : CodeW'(s[0]);
  endfunction

  logic             captured;
  logic [CodeW-1:0] strapCode;
  logic [AddrW-1:0] effAddr;

  assign strapCode = CodeW'(3 * level(strapA) + level(strapB));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      captured  <= 1'b0;
      slaveAddr <= '0;
      spiMode   <= 1'b0;
    end else if (!captured) begin
      captured  <= 1'b1;
      spiMode   <= (strapCode == CodeW'(SpiCode));
      slaveAddr <= (strapCode == CodeW'(SpiCode)) ? '0 : BaseAddr + SlvW'(strapCode);
    end
  end

  assign effAddr = spiMode ? {1'b0, addr[AddrW-2:0]} : addr;

  for (genvar i = 0; i < Regs; i++) begin : g_dec
    assign strobe.wrSel[i] = wrEn && (effAddr == AddrW'(i));
    assign strobe.rdSel[i] = rdEn && (effAddr == AddrW'(i));
  end

  // R3: straps are latched once and held
  a_r3_strap_hold: assert property (@(posedge clk) disable iff (!rstN)
    captured && $past(captured) |-> $stable(slaveAddr) && $stable(spiMode));
  // R5: at most one register selected
  a_r5_onehot_sel: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobe.wrSel) && $onehot0(strobe.rdSel));
  // R2: spi mode carries no slave address
  a_r2_spi_addr: assert property (@(posedge clk) disable iff (!rstN)
    spiMode |-> slaveAddr == '0);
endmodule

// File: rtl/clkcfg_data.sv
module clkcfg_data
  import clkcfg_pkg::*;
#(
  parameter int Regs  = NumRegs,
  parameter int Width = DataW,
  parameter int SW    = StatW
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobe_t               strobe,
  input  logic [Width-1:0]      wrData,
  input  logic [SW-1:0]         statusIn,
  output logic [Width-1:0]      rdData,
  output logic [Regs*Width-1:0] regBus,
  output logic                  mrPulse
);
  logic [Width-1:0] regs [Regs];

  assign mrPulse = regs[CtrlBIdx][SwRstBit];

  for (genvar i = 0; i < Regs; i++) begin : g_reg
    if (i == StatusIdx) begin : g_stat
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)        regs[i] <= rstVal(i);
        else if (mrPulse) regs[i] <= rstVal(i);
        else              regs[i] <= {1'b0, statusIn, 2'b00};
      end
    end else begin : g_cfg
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                 regs[i] <= rstVal(i);
        else if (mrPulse)          regs[i] <= rstVal(i);
        else if (strobe.wrSel[i])  regs[i] <= wrData & wrMask(i);
      end
    end
    assign regBus[i*Width +: Width] = regs[i];

    // R7/R8: reserved and forced-zero bits never become set
    a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
      (regs[i] & ~(wrMask(i) | ((i == StatusIdx) ? 8'h7C : 8'h00))) == '0);
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < Regs; i++)
      if (strobe.rdSel[i]) rdData = rdData | regs[i];
  end

  // R10: software reset bit write yields a pulse next cycle
  a_r10_mr_pulse: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrSel[CtrlBIdx] && wrData[SwRstBit] && !mrPulse |=> mrPulse);
  // R10: pulse lasts one cycle and restores defaults
  a_r10_defaults: assert property (@(posedge clk) disable iff (!rstN)
    mrPulse |=> !mrPulse && regs[5] == rstVal(5) && regs[0] == '0);
  // R9: status follows inputs with one cycle delay
  a_r9_status: assert property (@(posedge clk) disable iff (!rstN)
    !mrPulse |=> regs[StatusIdx] == {1'b0, $past(statusIn), 2'b00});
endmodule

// File: rtl/clkcfg_regs.sv
module clkcfg_regs
  import clkcfg_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  strapA,
  input  logic [1:0]  strapB,
  input  logic        wrEn,
  input  logic        rdEn,
  input  logic [7:0]  addr,
  input  logic [7:0]  wrData,
  output logic [7:0]  rdData,
  input  logic [4:0]  statusIn,
  output logic [6:0]  slaveAddr,
  output logic        spiMode,
  output logic        mrPulse,
  output logic [7:0]  divP,
  output logic [14:0] divM,
  output logic [2:0]  divN0,
  output logic [2:0]  divN1,
  output logic [7:0]  ctrlA,
  output logic [7:0]  ctrlB
);
  strobe_t                  strobe;
  logic [NumRegs*DataW-1:0] regBus;

  clkcfg_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .strapA(strapA), .strapB(strapB),
    .wrEn(wrEn), .rdEn(rdEn), .addr(addr), .strobe(strobe),
    .slaveAddr(slaveAddr), .spiMode(spiMode)
  );

  clkcfg_data u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(wrData),
    .statusIn(statusIn), .rdData(rdData), .regBus(regBus), .mrPulse(mrPulse)
  );

  assign divP  = regBus[0*DataW +: DataW];
  assign divM  = {regBus[1*DataW +: DataW], regBus[2*DataW+1 +: DataW-1]};
  assign divN0 = regBus[3*DataW+5 +: 3];
  assign divN1 = regBus[4*DataW+5 +: 3];
  assign ctrlA = regBus[5*DataW +: DataW];
  assign ctrlB = regBus[6*DataW +: DataW];
endmodule

// File: tb/clkcfg_regs_tb.sv
module clkcfg_regs_tb;
  logic        clk = 0, rstN = 0;
  logic [1:0]  strapA = 0, strapB = 0;
  logic        wrEn = 0, rdEn = 0;
  logic [7:0]  addr = 0, wrData = 0, rdData;
  logic [4:0]  statusIn = 0;
  logic [6:0]  slaveAddr;
  logic        spiMode, mrPulse;
  logic [7:0]  divP, ctrlA, ctrlB;
  logic [14:0] divM;
  logic [2:0]  divN0, divN1;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  clkcfg_regs u_dut (.*);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doReset(logic [1:0] a, logic [1:0] b);
    @(negedge clk); rstN = 0; strapA = a; strapB = b;
    @(negedge clk); rstN = 1;
    @(negedge clk); @(negedge clk);
  endtask

  task automatic wr(logic [7:0] ad, logic [7:0] d);
    addr = ad; wrData = d; wrEn = 1;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rdChk(string req, logic [7:0] ad, logic [7:0] exp);
    addr = ad; rdEn = 1; #1;
    check(req, rdData, exp);
    rdEn = 0; #1;
  endtask

  task automatic testStraps();
    for (int a = 0; a < 3; a++)
      for (int b = 0; b < 3; b++) begin
        doReset(2'(a), 2'(b));
        check("R2", spiMode, (a == 2 && b == 2));
        check("R1", slaveAddr, (a == 2 && b == 2) ? 0 : 7'h68 + 3*a + b);
      end
    doReset(2'b11, 2'b01);
    check("R1", slaveAddr, 7'h6F);
    doReset(2'b00, 2'b01);
    strapA = 2'b10; strapB = 2'b10;
    repeat (3) @(negedge clk);
    check("R3", slaveAddr, 7'h69);
    check("R3", spiMode, 0);
  endtask

  task automatic testDefaults();
    doReset(0, 0);
    for (int i = 0; i < 9; i++) rdChk("R4", 8'(i), (i == 5) ? 8'h60 : 8'h00);
    check("R12", rdData, 0);
    check("R11", ctrlA, 8'h60);
  endtask

  task automatic testMasks();
    doReset(0, 0);
    wr(0, 8'hA5); wr(1, 8'hC3); wr(2, 8'hFF); wr(3, 8'hFF); wr(4, 8'h7F);
    wr(6, 8'hEF); wr(8, 8'hFF);
    rdChk("R7", 2, 8'hFE); rdChk("R7", 3, 8'hE0); rdChk("R7", 4, 8'h60);
    rdChk("R8", 6, 8'hE6); rdChk("R7", 8, 8'h00);
    check("R11", divP, 8'hA5);
    check("R11", divM, {8'hC3, 7'h7F});
    check("R11", divN0, 3'd7);
    check("R11", divN1, 3'd3);
    check("R11", ctrlB, 8'hE6);
  endtask

  task automatic testStatus();
    doReset(0, 0);
    statusIn = 5'b10110;
    @(negedge clk);
    rdChk("R9", 7, 8'h58);
    wr(7, 8'hFF);
    rdChk("R9", 7, 8'h58);
    statusIn = 5'b01001;
    @(negedge clk);
    rdChk("R9", 7, 8'h24);
  endtask

  task automatic testDecode();
    doReset(0, 0);
    wr(8'h85, 8'h12); wr(8'h09, 8'h34);
    rdChk("R5", 5, 8'h60);
    wr(8'h01, 8'h77);
    rdChk("R5", 8'h81, 8'h00);
    rdChk("R5", 8'h09, 8'h00);
    doReset(2'b10, 2'b11);
    check("R6", spiMode, 1);
    wr(8'h81, 8'hAB);
    rdChk("R6", 8'h01, 8'hAB);
    rdChk("R6", 8'h85, 8'h60);
  endtask

  task automatic testSoftReset();
    doReset(0, 2'b10);
    wr(0, 8'h33); wr(5, 8'h01);
    check("R10", mrPulse, 0);
    strapA = 2'b10; strapB = 2'b10;
    wr(6, 8'h10);
    check("R10", mrPulse, 1);
    @(negedge clk);
    check("R10", mrPulse, 0);
    rdChk("R10", 0, 8'h00); rdChk("R10", 5, 8'h60); rdChk("R10", 6, 8'h00);
    check("R3", slaveAddr, 7'h6A);
    check("R3", spiMode, 0);
  endtask

  initial begin
    fork
      begin
        testStraps(); testDefaults(); testMasks();
        testStatus(); testDecode(); testSoftReset();
      end
      begin
        repeat (20000) @(posedge clk);
        check("watchdog", 1, 0);
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule